// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt lines into banks of 32 and presents them to a parent interrupt controller as a single level request. The bank count is set by a parameter to one or two. Every input passes through a two-flop synchronizer. The synchronized value is the raw status of that source. A per-source mask decides whether an active source counts as pending. A source stays pending only while its input is held high. Nothing is latched, so the condition clears when the source drops its line or software masks it.

Software reaches the block through a simple synchronous register bus with a byte address, a write strobe, write data and registered read data. Each bank takes a 0x20-byte window. Inside the window are five registers:

- a read-only status word;
- a read/write mask word;
- a write-one-to-set mask alias;
- a write-one-to-clear mask alias;
- a read-only pending word.

The two aliases let software enable or disable single sources without a read-modify-write. The request output is registered and is high whenever any bank has a nonzero pending word.

Top module: `banked_irq_ctrl`

## Requirements
- R1: The status word of a bank (offset 0x00) returns the source inputs delayed by two clock edges through the synchronizer.
- R2: After reset every mask bit is 1, every pending word reads zero and the request output is low.
- R3: A write to offset 0x04 replaces the bank's mask with the write data, and a read of 0x04 returns the mask.
- R4: A write to offset 0x08 sets the mask bits where the data has ones. A write to offset 0x0C clears the mask bits where the data has ones. Reads of 0x08 and 0x0C return zero.
- R5: The pending word (offset 0x10) equals status AND NOT mask, so a mask bit of 1 disables its source. It follows the synchronized level with no latching.
- R6: The request output is high one clock edge after any bank's pending word becomes nonzero, and low one clock edge after all pending words become zero.
- R7: Bank i occupies byte addresses i*0x20 to i*0x20+0x1F. Its bit n carries source input i*32+n.
- R8: Reads of any other offset, of an offset with address bits [1:0] nonzero, or of a bank index at or above the bank count return zero. Writes to those addresses change no mask.
- R9: Read data is registered: the bus_rdata value for an address appears after the first rising edge at which that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Level interrupt sources, asynchronous |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level request to the parent controller |

## Verification
Two events can land in the same cycle: a mask write through an alias, and a change on a source line. The bench raises a source in the very cycle it writes the clear-mask alias for that source. It then expects the request to stay low until the synchronized level arrives, and to rise exactly three edges after the stimulus. In the reverse case the bench masks an active source through the set-mask alias. It expects the request to drop two edges later, because the registered output still samples the old pending word at the first edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned SRC_PER_BANK   = 32;
  localparam int unsigned BANK_SPAN_LOG2 = 5;

  localparam logic [BANK_SPAN_LOG2-1:0] OFS_STATUS = 5'h00;
  localparam logic [BANK_SPAN_LOG2-1:0] OFS_MASK   = 5'h04;
  localparam logic [BANK_SPAN_LOG2-1:0] OFS_SET    = 5'h08;
  localparam logic [BANK_SPAN_LOG2-1:0] OFS_CLR    = 5'h0C;
  localparam logic [BANK_SPAN_LOG2-1:0] OFS_PEND   = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_SET,
    SEL_CLR,
    SEL_PEND
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [BANK_SPAN_LOG2-1:0] ofs);
    case (ofs)
      OFS_STATUS: return SEL_STATUS;
      OFS_MASK:   return SEL_MASK;
      OFS_SET:    return SEL_SET;
      OFS_CLR:    return SEL_CLR;
      OFS_PEND:   return SEL_PEND;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // Status lags the raw inputs by exactly two edges once out of reset.
  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = SRC_PER_BANK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic         wr_en_i,
  input  reg_sel_e     wr_sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_MASK: mask_q <= wdata_i;
        SEL_SET:  mask_q <= mask_q | wdata_i;
        SEL_CLR:  mask_q <= mask_q & ~wdata_i;
        default:  mask_q <= mask_q;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign pend_o = status_i & ~mask_q;

  assert_mask_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q));

  assert_set_alias_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == SEL_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == SEL_CLR) |=> ((mask_q & $past(wdata_i)) == '0));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(mask_q));

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_i,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_we,
  input  logic [SRC_PER_BANK-1:0]         bus_wdata,
  output logic [SRC_PER_BANK-1:0]         bus_rdata,
  output logic                            irq_o
);

  localparam int unsigned W          = SRC_PER_BANK;
  localparam int unsigned BANK_IDX_W = ADDR_W - BANK_SPAN_LOG2;

  logic [BANK_IDX_W-1:0]     bank_idx;
  logic [BANK_SPAN_LOG2-1:0] ofs;
  reg_sel_e                  sel;
  logic                      mask_wr;

  assign bank_idx = bus_addr[ADDR_W-1:BANK_SPAN_LOG2];
  assign ofs      = bus_addr[BANK_SPAN_LOG2-1:0];
  assign sel      = decode_ofs(ofs);
  assign mask_wr  = bus_we && (sel == SEL_MASK || sel == SEL_SET || sel == SEL_CLR);

  logic [W-1:0]         stat_w [NUM_BANKS];
  logic [W-1:0]         mask_w [NUM_BANKS];
  logic [W-1:0]         pend_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] pend_nz;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = (bank_idx == BANK_IDX_W'(b));

    irq_src_sync #(.W(W)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (src_i[b*W +: W]),
      .q_o (stat_w[b])
    );

    irq_bank_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .status_i (stat_w[b]),
      .wr_en_i  (mask_wr && bank_hit[b]),
      .wr_sel_i (sel),
      .wdata_i  (bus_wdata),
      .mask_o   (mask_w[b]),
      .pend_o   (pend_w[b])
    );

    assign pend_nz[b] = |pend_w[b];
  end

  logic [W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (sel)
          SEL_STATUS: rd_next = stat_w[b];
          SEL_MASK:   rd_next = mask_w[b];
          SEL_PEND:   rd_next = pend_w[b];
          default:    rd_next = '0;
        endcase
      end
    end
  end

  logic [W-1:0] rdata_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_next;
      irq_q   <= |pend_nz;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  logic readable;
  assign readable = (|bank_hit) && (sel == SEL_STATUS || sel == SEL_MASK || sel == SEL_PEND);

  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !readable |=> (bus_rdata == '0));

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (|pend_nz) |=> irq_o);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !(|pend_nz) |=> !irq_o);

endmodule

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;

  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB*32-1:0] src = '0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R2 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h04, v); chk("R2 bank0 mask", v, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R2 bank1 mask", v, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R2 bank0 pending", v, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    src[5] = 1'b1; src[40] = 1'b1;
    settle();
    rd(8'h00, v); chk("R1 bank0 status", v, 32'h0000_0020);
    rd(8'h20, v); chk("R7 bank1 status bit 8", v, 32'h0000_0100);
    rd(8'h10, v); chk("R5 masked source not pending", v, 32'h0);
    chk("R6 irq low while masked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask_write();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_00FF);
    rd(8'h04, v); chk("R3 mask readback", v, 32'hFFFF_00FF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R3 mask restore", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_clr();
    logic [31:0] v;
    wr(8'h0C, 32'h0000_0021);
    rd(8'h04, v); chk("R4 clear alias", v, 32'hFFFF_FFDE);
    rd(8'h0C, v); chk("R4 clear alias reads zero", v, 32'h0);
    rd(8'h08, v); chk("R4 set alias reads zero", v, 32'h0);
    wr(8'h08, 32'h0000_0001);
    rd(8'h04, v); chk("R4 set alias", v, 32'hFFFF_FFDF);
    rd(8'h10, v); chk("R5 pending enabled source", v, 32'h0000_0020);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_level();
    logic [31:0] v;
    src[5] = 1'b0;
    settle();
    rd(8'h10, v); chk("R5 pending drops with level", v, 32'h0);
    chk("R6 irq drops", {31'b0, irq}, 32'h0);
    src[5] = 1'b1;
    settle();
    rd(8'h10, v); chk("R5 pending returns", v, 32'h0000_0020);
  endtask

  task automatic t_irq_timing();
    logic [31:0] v;
    src = '0;
    repeat (2) @(negedge clk);
    chk("R6 irq still high two edges after drop", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq low third edge", {31'b0, irq}, 32'h0);
    wr(8'h2C, 32'h0000_0100);
    src[40] = 1'b1;
    settle();
    rd(8'h30, v); chk("R7 bank1 pending bit 8", v, 32'h0000_0100);
    chk("R6 irq from bank1", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_same_cycle();
    src = '0;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    settle();
    src[3] = 1'b1; addr = 8'h0C; wdata = 32'h8; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk("R6 same cycle edge1", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 same cycle edge2", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 same cycle edge3", {31'b0, irq}, 32'h1);
    addr = 8'h08; wdata = 32'h8; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk("R6 mask set edge1", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 mask set edge2", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    src[0] = 1'b1;
    settle();
    rd(8'h14, v); chk("R8 unused offset", v, 32'h0);
    rd(8'h40, v); chk("R8 bank beyond count", v, 32'h0);
    rd(8'h01, v); chk("R8 unaligned status", v, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h05, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'hEC, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R8 bank0 mask untouched", v, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R8 bank1 mask untouched", v, 32'hFFFF_FFFF);
    chk("R8 irq untouched", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    wr(8'h0C, 32'h1);
    rd(8'h04, v); chk("R9 mask read", v, 32'hFFFF_FFFE);
    addr = 8'h10;
    #1;
    chk("R9 old data before edge", rdata, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R9 new data after edge", rdata, 32'h0000_0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_mask_write();
    t_set_clr();
    t_level();
    t_irq_timing();
    t_same_cycle();
    t_unmapped();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule